// File: doc/BRIEF.md
# Outbound Byte Mailbox with Busy Handshake

This block carries short messages from a small controller to a host-side consumer. The controller sees a 256-byte register window on a simple byte bus, which has an address, a write strobe, a read strobe and data in both directions. It pushes message bytes one at a time through a single data-port address, and they are appended to a staging buffer. It then writes a commit bit to the control/status register. Committing freezes the staged bytes as one message and raises a busy flag. The consumer sees the message as `msgValid`, the byte count `msgLen` and an indexed read port into the buffer. It releases the message by pulsing `msgAck`.

The controller polls busy at bit 0 of the status register before it builds the next message. While busy is set, data-port writes are ignored. This keeps the message the consumer is reading stable. Bytes written after the buffer is full are dropped, and the loss is recorded in a sticky overflow flag at bit 1 of the status register.

Top module: `out_mailbox`

## Requirements
- R1: After reset, `msgValid` is 0, `msgLen` is 0 and a read of the status register (offset 0x85) returns 0x00.
- R2: While busy is 0, a write to the data port (offset 0x80) appends the byte at the next staging index, starting from index 0.
- R3: While busy is 0 and at least one byte is staged, a write to offset 0x85 with bit 0 set commits the message. From the next cycle, `msgValid` is 1, `msgLen` equals the number of staged bytes, and status bit 0 (busy) reads 1.
- R4: While `msgValid` is 1, `rdByte` returns the byte at index `rdIdx`, in the order the bytes were written.
- R5: The buffer holds 16 bytes. A data-port write while 16 bytes are staged is dropped and sets status bit 1 (overflow). Overflow stays set until a successful commit clears it.
- R6: Data-port writes while busy is 1 are ignored. `msgLen` and every buffer byte stay unchanged.
- R7: A commit write is ignored when no bytes are staged, and also when bit 0 of the written value is 0.
- R8: When `msgAck` is high while `msgValid` is 1, on the next cycle `msgValid` is 0, `msgLen` is 0, busy reads 0 and the staging buffer is empty.
- R9: With `busRd` high, a read of the status register returns {6'b0, overflow, busy}. A read of the data port or of any other offset returns 0. `msgAck` while `msgValid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Register offset within the window |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| msgValid | output | 1 | A committed message is held |
| msgLen | output | 5 | Byte count of the held message, 0 when none |
| rdIdx | input | 4 | Consumer byte index |
| rdByte | output | 8 | Buffer byte at `rdIdx` |
| msgAck | input | 1 | Consumer releases the message |

## Verification
The bench sweeps every message length from 1 to 16 with distinct byte patterns. For each length it reads back every byte, which catches an off-by-one staging index or a length latched from the wrong count. It then writes into the data port while the message is held. A design that lets these writes through would corrupt the consumer's bytes or grow `msgLen`. The bench also drives the buffer two bytes past full, commits with an empty buffer, and commits with bit 0 clear. A design with a non-sticky overflow flag fails the first of these, and a design that commits on any status write fails the last two. Finally it acks with nothing held and checks that the next message starts again at index 0. A stale write pointer would shift that message.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef struct packed {
    logic push;
    logic clear;
  } mboxStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h80,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h85,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              commitBit,
  input  logic [CNT_W-1:0]  stagedCount,
  input  logic              msgAck,
  output mboxStrobes_t      strobes,
  output logic              busy,
  output logic [7:0]        busRdata
);
  logic overflow;
  logic dataWr, statWr, full, commitOk, ackFire;

  assign dataWr   = busWr && (busAddr == DATA_OFF);
  assign statWr   = busWr && (busAddr == STAT_OFF);
  assign full     = (stagedCount == CNT_W'(DEPTH));
  assign commitOk = statWr && commitBit && !busy && (stagedCount != '0);
  assign ackFire  = busy && msgAck;

  always_comb begin
    strobes.push  = dataWr && !busy && !full;
    strobes.clear = ackFire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (commitOk)     busy <= 1'b1;
      else if (ackFire) busy <= 1'b0;
      if (commitOk)                     overflow <= 1'b0;
      else if (dataWr && !busy && full) overflow <= 1'b1;
    end
  end

  always_comb begin
    busRdata = 8'h00;
    if (busRd && busAddr == STAT_OFF) busRdata = {6'b0, overflow, busy};
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  mboxStrobes_t     strobes,
  input  logic [7:0]       wrByte,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [CNT_W-1:0] stagedCount,
  output logic [7:0]       rdByte
);
  logic [7:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedCount <= '0;
    end else if (strobes.clear) begin
      stagedCount <= '0;
    end else if (strobes.push) begin
      stagedCount <= stagedCount + 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.push && stagedCount[IDX_W-1:0] == IDX_W'(g))
        stage[g] <= wrByte;
    end
  end

  assign rdByte = stage[rdIdx];
endmodule

// File: rtl/out_mailbox.sv
module out_mailbox
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h80,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h85,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  output logic              msgValid,
  output logic [CNT_W-1:0]  msgLen,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [7:0]        rdByte,
  input  logic              msgAck
);
  mboxStrobes_t strobes;
  logic busy;
  logic [CNT_W-1:0] stagedCount;

  mbox_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .STAT_OFF(STAT_OFF)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .commitBit(busWdata[0]), .stagedCount(stagedCount), .msgAck(msgAck),
    .strobes(strobes), .busy(busy), .busRdata(busRdata)
  );

  mbox_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrByte(busWdata),
    .rdIdx(rdIdx), .stagedCount(stagedCount), .rdByte(rdByte)
  );

  assign msgValid = busy;
  assign msgLen   = busy ? stagedCount : '0;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int DEPTH = 16,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFF = 'h80,
  parameter logic [ADDR_W-1:0] STAT_OFF = 'h85,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [7:0]        busWdata,
  input logic              msgValid,
  input logic [CNT_W-1:0]  msgLen,
  input logic              msgAck,
  input logic [CNT_W-1:0]  stagedCount
);
  // R3: a valid commit raises msgValid with the staged length
  a_r3_commit: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == STAT_OFF && busWdata[0] && !msgValid && stagedCount != '0)
    |=> (msgValid && msgLen == $past(stagedCount)));

  // R6: while held and not acked, the message stays put
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgAck) |=> (msgValid && $stable(msgLen) && $stable(stagedCount)));

  // R7: an empty commit does not raise msgValid
  a_r7_empty_commit: assert property (@(posedge clk) disable iff (!rstN)
    (!msgValid && stagedCount == '0 && !(busWr && busAddr == DATA_OFF)) |=> !msgValid);

  // R8: ack releases the message and empties the buffer
  a_r8_ack_release: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgAck) |=> (!msgValid && msgLen == '0 && stagedCount == '0));

  // R5: staged count never passes the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    stagedCount <= CNT_W'(DEPTH));
endmodule

bind out_mailbox mbox_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_OFF(DATA_OFF), .STAT_OFF(STAT_OFF)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .msgValid(msgValid), .msgLen(msgLen), .msgAck(msgAck), .stagedCount(stagedCount)
);

// File: tb/out_mailbox_bench.sv
module out_mailbox_bench;
  logic clk = 0;
  logic rstN = 0;
  logic [7:0] busAddr = 0;
  logic busWr = 0, busRd = 0, msgAck = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata, rdByte;
  logic msgValid;
  logic [4:0] msgLen;
  logic [3:0] rdIdx = 0;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  out_mailbox u_out_mailbox (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .msgValid(msgValid), .msgLen(msgLen),
    .rdIdx(rdIdx), .rdByte(rdByte), .msgAck(msgAck)
  );

  task automatic check(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    busAddr = a; busRd = 1; #1;
    v = busRdata;
    busRd = 0;
  endtask

  task automatic ack();
    @(negedge clk); msgAck = 1;
    @(negedge clk); msgAck = 0;
  endtask

  function automatic logic [7:0] pat(int len, int i);
    return 8'((len * 17 + i * 29) ^ 8'h5A);
  endfunction

  task automatic checkBytes(string req, int len, int seed);
    for (int i = 0; i < len; i++) begin
      rdIdx = 4'(i); #1;
      check(req, rdByte, pat(seed, i));
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    check("R1 valid", msgValid, 0);
    check("R1 len", msgLen, 0);
    rd(8'h85, v); check("R1 status", v, 0);
    // R9 reads
    rd(8'h80, v); check("R9 data read", v, 0);
    rd(8'h12, v); check("R9 other read", v, 0);
    // R9 ack while idle, R7 empty commit and bit0=0 commit
    ack();
    check("R9 idle ack", msgValid, 0);
    wr(8'h85, 8'h01);
    check("R7 empty commit", msgValid, 0);
    wr(8'h80, 8'hAB);
    wr(8'h85, 8'h00);
    check("R7 bit0 clear", msgValid, 0);
    wr(8'h85, 8'h01);
    check("R3 single valid", msgValid, 1);
    check("R2 single len", msgLen, 1);
    rdIdx = 0; #1; check("R4 single byte", rdByte, 8'hAB);
    ack();
    check("R8 released", msgValid, 0);
    // sweep lengths 1..16
    for (int len = 1; len <= 16; len++) begin
      for (int i = 0; i < len; i++) wr(8'h80, pat(len, i));
      rd(8'h85, v); check("R3 idle status", v, 0);
      check("R2 not valid before commit", msgValid, 0);
      wr(8'h85, 8'h01);
      check("R3 valid", msgValid, 1);
      check("R3 len", msgLen, len);
      rd(8'h85, v); check("R9 busy status", v, 8'h01);
      checkBytes("R4 bytes", len, len);
      wr(8'h80, 8'hEE);
      wr(8'h85, 8'h01);
      check("R6 len held", msgLen, len);
      checkBytes("R6 bytes held", len, len);
      ack();
      check("R8 valid low", msgValid, 0);
      check("R8 len zero", msgLen, 0);
      rd(8'h85, v); check("R8 status idle", v, 0);
    end
    // R5 overflow
    for (int i = 0; i < 18; i++) wr(8'h80, pat(40, i));
    rd(8'h85, v); check("R5 overflow set", v, 8'h02);
    wr(8'h80, 8'h11);
    rd(8'h85, v); check("R5 overflow sticky", v, 8'h02);
    wr(8'h85, 8'h01);
    check("R5 len capped", msgLen, 16);
    rd(8'h85, v); check("R5 overflow cleared", v, 8'h01);
    checkBytes("R5 first bytes kept", 16, 40);
    ack();
    // R8 buffer empty: new message starts at index 0
    wr(8'h80, 8'h3C);
    wr(8'h85, 8'h01);
    check("R8 restart len", msgLen, 1);
    rdIdx = 0; #1; check("R8 restart byte", rdByte, 8'h3C);
    ack();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule